// File: doc/BRIEF.md
# Cascadable Serial Control-Word Decoder

This block sits behind a serial port of a codec-style device that can be chained with others of its kind. Words of sixteen bits arrive one bit per clock, most significant bit first. A one-cycle pulse on the frame-sync input marks the first bit of each word. Each word is either a control word or a data word. A control word carries a hop count in place of a device select. When the hop count is zero the word belongs to this device: it writes one of six 8-bit control registers, or it reads one back. When the hop count is not zero, the block lowers the count by one and sends the word out on its serial output, toward the next device in the chain.

A read does not use a separate return path. The block places the selected register's value in the word's data byte and sends the altered word out. The output frame starts one word time after the input frame, so a chain of devices behaves like a pipeline of word-long delays. Bit 0 of register 0 selects the mode. In program mode (0), a word with its control flag low is invalid and is dropped. In mixed mode (1), such a word is a data word and is handed to the local datapath. Bit 7 of register 0 is a soft reset. It clears every register after a fixed number of cycles, the same time the hardware reset sequence takes. No output frame is produced until a fixed start-up delay after hardware reset has passed.

Top module: `cascade_ctl_decoder`

## Requirements
- R1: A word with bit 15 = 1 and a nonzero hop count in bits 13:11 is re-emitted on `sdo_o` with the hop count lowered by one and every other bit unchanged. `fs_o` is high in the cycle after the word's last input bit, together with output bit 15, and the remaining bits follow MSB first on the next 15 cycles.
- R2: A word with bit 15 = 1, bit 14 = 0, hop count 0 and register select (bits 10:8) below 6 loads bits 7:0 into that register, which appears at `ctrl_regs_o[8*sel +: 8]`. It produces no output frame.
- R3: A word with bit 15 = 1, bit 14 = 1 and hop count 0 is re-emitted in the same output timing as R1. Its bits 15:8 are unchanged and bits 7:0 are replaced by the selected register's value. No register changes.
- R4: Register selects 6 and 7 are reserved. A write to them changes no register, and a read from them returns 0x00 in bits 7:0.
- R5: While bit 0 of register 0 is 0 (program mode), a word with bit 15 = 0 is ignored. It changes no register, raises no `data_valid_o` and produces no output frame, whatever its hop count.
- R6: While bit 0 of register 0 is 1 (mixed mode), a word with bit 15 = 0 raises `data_valid_o` for one cycle, in the cycle after its last bit, with the whole word on `data_word_o`. It changes no register and is not forwarded.
- R7: During and after hardware reset, all six registers read 0x00 and `fs_o`, `sdo_o` and `data_valid_o` are low.
- R8: A write of a value with bit 7 set to register 0 stores that value. All six registers then clear to 0x00 on the fourth clock after the write, which also clears bit 7 itself and returns the block to program mode.
- R9: `fs_o` stays low for the first 2048 cycles after hardware reset is released. Words that complete in that time produce no output frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sdi_i | input | 1 | Serial word input, MSB first |
| fs_i | input | 1 | One-cycle pulse marking bit 15 of an input word |
| sdo_o | output | 1 | Serial word output toward the next device, MSB first, low when idle |
| fs_o | output | 1 | One-cycle pulse marking bit 15 of an output word |
| ctrl_regs_o | output | 48 | The six control registers, register n at bits 8n+7:8n |
| data_valid_o | output | 1 | One-cycle strobe for a data word in mixed mode |
| data_word_o | output | 16 | Last data word received in mixed mode |

## Verification
The assertions assume that every input word is a full sixteen bits, with exactly one frame-sync pulse at its first bit. They also assume that no new frame sync lands inside a word. The stimulus keeps to this: every word goes through one send task that emits a single pulse and then sixteen bits, and each word is followed by idle cycles long enough for the output frame to drain. The checks on mode-dependent behaviour rely on register 0 being known before each word. The bench therefore models every write, soft reset included, and spaces the words widely enough that the four-cycle clear has always finished before the next word is decoded.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

   // what a completed input word asks the block to do
   typedef enum logic [2:0] {
      ACT_NONE  = 3'd0,
      ACT_FWD   = 3'd1,
      ACT_WRITE = 3'd2,
      ACT_READ  = 3'd3,
      ACT_DATA  = 3'd4
   } ccd_act_e;

   // bit positions inside control register 0 that the block itself decodes
   localparam int MODE_BIT     = 0;
   localparam int SOFT_RST_BIT = 7;

endpackage

// File: rtl/ccd_deser.sv
module ccd_deser #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdi,
   input  logic              fs,
   output logic              done,
   output logic [WORD_W-1:0] word
);
   localparam int CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q  <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else begin
         shift_q <= {shift_q[WORD_W-2:0], sdi};
         if (fs) begin
            cnt_q    <= CNT_W'(1);
            active_q <= 1'b1;
         end else if (active_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(WORD_W - 1)) active_q <= 1'b0;
         end
      end
   end

   assign done = active_q && !fs && (cnt_q == CNT_W'(WORD_W - 1));
   assign word = {shift_q[WORD_W-2:0], sdi};

endmodule

// File: rtl/ccd_ser.sv
module ccd_ser #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   output logic              sdo,
   output logic              fs
);
   logic [WORD_W-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         fs      <= 1'b0;
      end else if (load) begin
         shift_q <= load_word;
         fs      <= 1'b1;
      end else begin
         shift_q <= {shift_q[WORD_W-2:0], 1'b0};
         fs      <= 1'b0;
      end
   end

   assign sdo = shift_q[WORD_W-1];

endmodule

// File: rtl/ccd_regbank.sv
module ccd_regbank
   import ccd_pkg::*;
#(
   parameter int NUM_REGS   = 6,
   parameter int REG_W      = 8,
   parameter int SEL_W      = 3,
   parameter int RST_CYCLES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [REG_W-1:0]          wr_data,
   input  logic [SEL_W-1:0]          rd_sel,
   output logic [REG_W-1:0]          rd_data,
   output logic [NUM_REGS*REG_W-1:0] regs_o,
   output logic                      busy
);
   localparam int CLR_W = $clog2(RST_CYCLES + 1);

   logic [CLR_W-1:0] clr_cnt_q;
   logic             clr_now;
   logic             soft_hit;

   assign busy     = (clr_cnt_q != '0);
   assign clr_now  = (clr_cnt_q == CLR_W'(1));
   assign soft_hit = wr_en && (wr_sel == '0) && wr_data[SOFT_RST_BIT];

   // reset sequencer shared by the pin reset and the soft-reset bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        clr_cnt_q <= CLR_W'(RST_CYCLES);
      else if (busy)     clr_cnt_q <= clr_cnt_q - CLR_W'(1);
      else if (soft_hit) clr_cnt_q <= CLR_W'(RST_CYCLES);
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (busy) begin
            if (clr_now) q <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            q <= wr_data;
         end
      end
      assign regs_o[g*REG_W +: REG_W] = q;
   end

   // selects beyond the last register read as zero
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_sel == SEL_W'(i)) rd_data = regs_o[i*REG_W +: REG_W];
      end
   end

endmodule

// File: rtl/cascade_ctl_decoder.sv
module cascade_ctl_decoder
   import ccd_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int ADDR_W     = 3,
   parameter int NUM_REGS   = 6,
   parameter int RST_CYCLES = 4,
   parameter int FS_DELAY   = 2048
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sdi_i,
   input  logic                          fs_i,
   output logic                          sdo_o,
   output logic                          fs_o,
   output logic [NUM_REGS*REG_W-1:0]     ctrl_regs_o,
   output logic                          data_valid_o,
   output logic [2+2*ADDR_W+REG_W-1:0]   data_word_o
);
   localparam int WORD_W  = 2 + 2*ADDR_W + REG_W;
   localparam int CD_BIT  = WORD_W - 1;
   localparam int RW_BIT  = WORD_W - 2;
   localparam int SEL_LSB = REG_W;
   localparam int DEV_LSB = REG_W + ADDR_W;
   localparam int DLY_W   = $clog2(FS_DELAY + 1);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("NUM_REGS must fit the register-select field");
   end
   if (REG_W <= SOFT_RST_BIT) begin : g_bad_width
      $error("REG_W must hold the soft-reset bit");
   end
   if (RST_CYCLES < 1 || FS_DELAY < 1) begin : g_bad_timing
      $error("RST_CYCLES and FS_DELAY must be positive");
   end

   logic              rx_done;
   logic [WORD_W-1:0] rx_word;
   logic              busy;
   logic [REG_W-1:0]  rd_data;
   logic [DLY_W-1:0]  start_cnt_q;
   logic              out_ready;
   ccd_act_e          act;
   logic [WORD_W-1:0] tx_word;
   logic              tx_load;
   logic [ADDR_W-1:0] hop;
   logic [ADDR_W-1:0] sel;
   logic              mode_mixed;

   ccd_deser #(.WORD_W(WORD_W)) rx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sdi   (sdi_i),
      .fs    (fs_i),
      .done  (rx_done),
      .word  (rx_word)
   );

   assign hop        = rx_word[DEV_LSB +: ADDR_W];
   assign sel        = rx_word[SEL_LSB +: ADDR_W];
   assign mode_mixed = ctrl_regs_o[MODE_BIT];

   always_comb begin
      act = ACT_NONE;
      if (rx_done) begin
         if (!rx_word[CD_BIT])  act = mode_mixed ? ACT_DATA : ACT_NONE;
         else if (hop != '0)    act = ACT_FWD;
         else if (rx_word[RW_BIT]) act = ACT_READ;
         else                   act = ACT_WRITE;
      end
   end

   ccd_regbank #(
      .NUM_REGS   (NUM_REGS),
      .REG_W      (REG_W),
      .SEL_W      (ADDR_W),
      .RST_CYCLES (RST_CYCLES)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (act == ACT_WRITE),
      .wr_sel  (sel),
      .wr_data (rx_word[REG_W-1:0]),
      .rd_sel  (sel),
      .rd_data (rd_data),
      .regs_o  (ctrl_regs_o),
      .busy    (busy)
   );

   always_comb begin
      tx_word = rx_word;
      if (act == ACT_FWD)  tx_word[DEV_LSB +: ADDR_W] = hop - ADDR_W'(1);
      if (act == ACT_READ) tx_word[REG_W-1:0] = rd_data;
   end

   // start-up delay before the first output frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          start_cnt_q <= '0;
      else if (!out_ready) start_cnt_q <= start_cnt_q + DLY_W'(1);
   end
   assign out_ready = (start_cnt_q == DLY_W'(FS_DELAY));
   assign tx_load   = out_ready && ((act == ACT_FWD) || (act == ACT_READ));

   ccd_ser #(.WORD_W(WORD_W)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_word (tx_word),
      .sdo       (sdo_o),
      .fs        (fs_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_valid_o <= 1'b0;
         data_word_o  <= '0;
      end else begin
         data_valid_o <= (act == ACT_DATA);
         if (act == ACT_DATA) data_word_o <= rx_word;
      end
   end

endmodule

// File: rtl/ccd_checker.sv
module ccd_checker #(
   parameter int WORD_W   = 16,
   parameter int REG_W    = 8,
   parameter int ADDR_W   = 3,
   parameter int NUM_REGS = 6,
   parameter int FS_DELAY = 2048
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      fs_o,
   input logic                      data_valid_o,
   input logic                      rx_done,
   input logic [WORD_W-1:0]         rx_word,
   input logic                      busy,
   input logic [NUM_REGS*REG_W-1:0] regs
);
   localparam int DLY_W = $clog2(FS_DELAY + 1);

   logic [DLY_W-1:0]  since_rst;
   logic              cd;
   logic              rw;
   logic [ADDR_W-1:0] hop;
   logic [ADDR_W-1:0] sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != DLY_W'(FS_DELAY)) since_rst <= since_rst + DLY_W'(1);
   end

   assign cd  = rx_word[WORD_W-1];
   assign rw  = rx_word[WORD_W-2];
   assign hop = rx_word[REG_W+ADDR_W +: ADDR_W];
   assign sel = rx_word[REG_W +: ADDR_W];

   // R9
   startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != DLY_W'(FS_DELAY)) |-> !fs_o);

   // R1
   frame_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_o |-> $past(rx_done));

   // R6
   data_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> !fs_o);

   // R5
   prog_mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !cd && !regs[0]) |=> (!fs_o && !data_valid_o));

   // R8
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (regs == '0));

   // R4
   reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && cd && !rw && (hop == '0) && (int'(sel) >= NUM_REGS) && !busy)
      |=> $stable(regs));

endmodule

bind cascade_ctl_decoder ccd_checker #(
   .WORD_W   (WORD_W),
   .REG_W    (REG_W),
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS),
   .FS_DELAY (FS_DELAY)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .fs_o         (fs_o),
   .data_valid_o (data_valid_o),
   .rx_done      (rx_done),
   .rx_word      (rx_word),
   .busy         (busy),
   .regs         (ctrl_regs_o)
);

// File: tb/cascade_ctl_decoder_tb_top.sv
module cascade_ctl_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdi = 1'b0;
   logic        fs = 1'b0;
   logic        sdo;
   logic        fs_o;
   logic [47:0] regs;
   logic        dvalid;
   logic [15:0] dword;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // monitor state
   int          out_frames = 0;
   logic [15:0] last_out = '0;
   int          mon_left = 0;
   logic [15:0] mon_acc = '0;
   int          data_hits = 0;
   logic [15:0] last_data = '0;

   logic [7:0] exp_regs [6];

   always #2 clk = ~clk;

   cascade_ctl_decoder dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sdi_i        (sdi),
      .fs_i         (fs),
      .sdo_o        (sdo),
      .fs_o         (fs_o),
      .ctrl_regs_o  (regs),
      .data_valid_o (dvalid),
      .data_word_o  (dword)
   );

   always @(negedge clk) begin
      if (mon_left > 0) begin
         mon_acc = {mon_acc[14:0], sdo};
         mon_left--;
         if (mon_left == 0) begin
            out_frames++;
            last_out = mon_acc;
         end
      end else if (fs_o) begin
         mon_acc  = {15'd0, sdo};
         mon_left = 15;
      end
      if (dvalid) begin
         data_hits++;
         last_data = dword;
      end
   end

   task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // ends at the falling edge right after the edge that takes the last bit
   task automatic send_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk);
         fs  = (i == 15);
         sdi = w[i];
      end
      @(negedge clk);
      fs  = 1'b0;
      sdi = 1'b0;
   endtask

   function automatic logic [47:0] exp_flat();
      logic [47:0] f;
      for (int i = 0; i < 6; i++) f[i*8 +: 8] = exp_regs[i];
      return f;
   endfunction

   function automatic logic [15:0] mk(input bit cd, input bit rw, input int dev,
                                      input int sel, input logic [7:0] d);
      return {cd, rw, 3'(dev), 3'(sel), d};
   endfunction

   task automatic hw_reset();
      rst_n = 1'b0;
      idle(3);
      check("R7 regs in reset", regs, 48'd0);
      check("R7 outputs in reset", {45'd0, fs_o, sdo, dvalid}, 48'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) exp_regs[i] = 8'h00;
   endtask

   // send one word, predict its effect from the requirements, compare
   task automatic run_word(input logic [15:0] w);
      int f0, d0, sel, dev;
      bit cd, rw, mixed;
      string tag;
      logic [15:0] exp_w;
      bit exp_frame, exp_data;
      f0 = out_frames;
      d0 = data_hits;
      cd = w[15]; rw = w[14]; dev = int'(w[13:11]); sel = int'(w[10:8]);
      mixed = exp_regs[0][0];
      exp_frame = 1'b0; exp_data = 1'b0; exp_w = w;
      if (!cd) begin
         if (mixed) begin exp_data = 1'b1; tag = "R6"; end
         else tag = "R5";
      end else if (dev != 0) begin
         exp_frame = 1'b1; exp_w[13:11] = 3'(dev - 1); tag = "R1";
      end else if (rw) begin
         exp_frame = 1'b1;
         exp_w[7:0] = (sel < 6) ? exp_regs[sel] : 8'h00;
         tag = (sel < 6) ? "R3" : "R4";
      end else if (sel < 6) begin
         exp_regs[sel] = w[7:0];
         if (sel == 0 && w[7]) begin
            for (int i = 0; i < 6; i++) exp_regs[i] = 8'h00;
            tag = "R8";
         end else tag = "R2";
      end else tag = "R4";
      send_word(w);
      idle(22);
      check({tag, " frame count"}, 48'(out_frames - f0), 48'(exp_frame));
      if (exp_frame) check({tag, " frame word"}, 48'(last_out), 48'(exp_w));
      check({tag, " data strobe"}, 48'(data_hits - d0), 48'(exp_data));
      if (exp_data) check({tag, " data word"}, 48'(last_data), 48'(w));
      check({tag, " registers"}, regs, exp_flat());
   endtask

   initial begin
      int f0;
      logic [15:0] w;
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 6; i++) exp_regs[i] = 8'h00;
      idle(2);
      hw_reset();

      // R9: a forwardable word during the start-up window gives no frame
      f0 = out_frames;
      send_word(mk(1, 0, 2, 0, 8'h3c));
      idle(40);
      check("R9 no early frame", 48'(out_frames - f0), 48'd0);
      idle(2100);

      // R1: exact launch cycle and bit order of a forwarded word
      send_word(mk(1, 1, 5, 3, 8'ha5));
      check("R1 fs_o with first output bit", {46'd0, fs_o, sdo}, 48'b11);
      idle(22);
      check("R1 forwarded word", 48'(last_out), 48'(mk(1, 1, 4, 3, 8'ha5)));

      // R2/R3/R4 directed
      run_word(mk(1, 0, 0, 5, 8'h6e));
      run_word(mk(1, 1, 0, 5, 8'h00));
      run_word(mk(1, 0, 0, 6, 8'hff));
      run_word(mk(1, 1, 0, 7, 8'h99));
      // R5 then R6: mode switch
      run_word(mk(0, 0, 0, 1, 8'h11));
      run_word(mk(1, 0, 0, 0, 8'h01));
      run_word(mk(0, 1, 3, 2, 8'h77));

      // R8: exact timing of the soft clear
      run_word(mk(1, 0, 0, 2, 8'h42));
      send_word(mk(1, 0, 0, 0, 8'h81));
      check("R8 value stored first", 48'(regs[7:0]), 48'h81);
      idle(3);
      check("R8 not cleared after 3 clocks", 48'(regs[7:0]), 48'h81);
      idle(1);
      check("R8 all clear on 4th clock", regs, 48'd0);
      for (int i = 0; i < 6; i++) exp_regs[i] = 8'h00;
      idle(20);

      // constrained random words
      for (int n = 0; n < 300; n++) begin
         w = 16'($urandom);
         w[15] = (($urandom % 6) != 0);
         w[13:11] = (($urandom % 4) == 0) ? 3'(1 + ($urandom % 7)) : 3'd0;
         if (w[10:8] == 3'd0 && w[7] && ($urandom % 3) != 0) w[7] = 1'b0;
         run_word(w);
      end

      // R7: hardware reset after activity clears everything
      run_word(mk(1, 0, 0, 4, 8'hc3));
      hw_reset();
      idle(2);
      check("R7 regs after release", regs, 48'd0);
      idle(2100);
      run_word(mk(1, 1, 0, 4, 8'h00));

      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         report();
         $finish;
      end
   end

endmodule